// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a 32-bit processor that finishes every instruction in one clock. On each rising edge it retires the instruction that the program counter selects. In that cycle it reads up to two of its 32 general registers, computes a result or an address, optionally reads or writes data memory, writes back, and moves the PC. It supports nine instructions: five register-to-register operations, a word load, a word store, a branch taken when two registers are equal, and an absolute jump. Any other encoding does nothing except advance the PC by one word.

Both memories are small word-indexed arrays inside the core. A loading port fills them, normally while reset is held. Three registered observation groups report what the last retired instruction did: the new PC, the register write-back and the store.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, each rising edge sets `pc_o` to 0 and clears `wb_we_o` and `st_we_o`. The register file is not cleared.
- R2: After an instruction retires, `pc_o` holds its address plus 4, unless a taken branch or a jump redirects it. An unsupported opcode, or opcode 0 with an unlisted function code, is a no-op that only advances the PC.
- R3: Opcode 0 selects the R-type group, with the function code in bits [5:0]: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR. These read rs [25:21] and rt [20:16] and write to rd [15:11].
- R4: Function code 0x2A (set-less-than) compares rs and rt as signed values and writes 1 or 0.
- R5: Register 0 always reads as zero. An instruction that targets it reports no write-back (`wb_we_o` stays 0) and does not change its value.
- R6: Opcode 0x23 loads the data word at address rs + sign-extended imm[15:0] into rt. Data memory is indexed by address bits [DAW+1:2].
- R7: Opcode 0x2B stores rt at address rs + sign-extended imm[15:0]. On the next cycle, `st_we_o`, `st_addr_o` and `st_data_o` report the store.
- R8: Opcode 0x04 compares rs with rt. If they are equal, the next PC is PC+4 plus the sign-extended offset shifted left by two. Otherwise the next PC is PC+4. An offset of -1 branches to the branch instruction itself.
- R9: Opcode 0x02 sets the PC to {(PC+4)[31:28], instr[25:0], 2'b00}.
- R10: With `ld_we` high, `ld_word` is written on a rising edge to word `ld_idx` of instruction memory (`ld_dmem`=0) or of data memory (`ld_dmem`=1). Instruction fetch uses PC bits [IAW+1:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Memory load strobe |
| ld_dmem | input | 1 | Load target: 0 instruction memory, 1 data memory |
| ld_idx | input | LOAD_AW | Word index for the load |
| ld_word | input | 32 | Word to load |
| pc_o | output | 32 | Current program counter |
| wb_we_o | output | 1 | Last retired instruction wrote a register |
| wb_idx_o | output | 5 | Register written |
| wb_data_o | output | 32 | Value written |
| st_we_o | output | 1 | Last retired instruction stored a word |
| st_addr_o | output | 32 | Byte address of the store |
| st_data_o | output | 32 | Stored word |

## Verification
Every retirement is visible on the ports one edge after it happens. A wrong decode, a wrong ALU result or a wrong destination therefore shows up in `wb_*_o` in the same cycle as the faulty instruction. A wrong branch or jump target shows up in `pc_o` at that same edge. A corrupted register or memory word stays hidden until a later instruction reads it, so the program reads back every loaded and computed value. The bench compares all three output groups on every cycle against a behavioural instruction-level model.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_J     = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    from_mem;
    logic    mem_we;
    logic    is_beq;
    logic    is_jump;
    logic    use_imm;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ctrl_t           ctrl
);
  logic [5:0] opc;
  logic [5:0] fn;
  assign opc = instr[31:26];
  assign fn  = instr[5:0];

  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    case (opc)
      OP_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_we = 1'b1;
        case (fn)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OP_LW: begin
        ctrl.reg_we   = 1'b1;
        ctrl.from_mem = 1'b1;
        ctrl.use_imm  = 1'b1;
      end
      OP_SW: begin
        ctrl.mem_we  = 1'b1;
        ctrl.use_imm = 1'b1;
      end
      OP_BEQ:  ctrl.is_beq  = 1'b1;
      OP_J:    ctrl.is_jump = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    AST_ONE_KIND: assert ($onehot0({ctrl.reg_we, ctrl.mem_we, ctrl.is_beq, ctrl.is_jump})); // R2
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y
);
  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int WIDTH = 32,
  parameter int COUNT = 32,
  localparam int IW = $clog2(COUNT)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IW-1:0]    widx,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IW-1:0]    ra1,
  input  logic [IW-1:0]    ra2,
  output logic [WIDTH-1:0] rd1,
  output logic [WIDTH-1:0] rd2
);
  logic [WIDTH-1:0] mem [COUNT];

  always_ff @(posedge clk) begin
    if (we && widx != '0) mem[widx] <= wdata;
  end

  assign rd1 = (ra1 == '0) ? '0 : mem[ra1];
  assign rd2 = (ra2 == '0) ? '0 : mem[ra2];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int LOAD_AW    = 8,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_we,
  input  logic               ld_dmem,
  input  logic [LOAD_AW-1:0] ld_idx,
  input  logic [XLEN-1:0]    ld_word,
  output logic [XLEN-1:0]    pc_o,
  output logic               wb_we_o,
  output logic [RIDX-1:0]    wb_idx_o,
  output logic [XLEN-1:0]    wb_data_o,
  output logic               st_we_o,
  output logic [XLEN-1:0]    st_addr_o,
  output logic [XLEN-1:0]    st_data_o
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];
  logic [XLEN-1:0] pc_q;

  logic [XLEN-1:0] instr, sext, rd1, rd2, alu_b, alu_y, mem_rd, wdata;
  logic [XLEN-1:0] pc_plus4, br_tgt, j_tgt, pc_next;
  logic [RIDX-1:0] widx;
  logic            rf_we, take_br;
  ctrl_t           ctrl;
  logic            unused_bits;

  assign instr = imem[pc_q[IAW+1:2]];
  assign sext  = {{(XLEN-16){instr[15]}}, instr[15:0]};

  sc_decode u_dec (.instr(instr), .ctrl(ctrl));

  sc_regfile #(.WIDTH(XLEN), .COUNT(32)) u_rf (
    .clk(clk), .we(rf_we), .widx(widx), .wdata(wdata),
    .ra1(instr[25:21]), .ra2(instr[20:16]), .rd1(rd1), .rd2(rd2)
  );

  assign alu_b = ctrl.use_imm ? sext : rd2;

  sc_alu u_alu (.a(rd1), .b(alu_b), .op(ctrl.alu_op), .y(alu_y));

  assign mem_rd = dmem[alu_y[DAW+1:2]];
  assign wdata  = ctrl.from_mem ? mem_rd : alu_y;
  assign widx   = ctrl.dst_rd ? instr[15:11] : instr[20:16];
  assign rf_we  = ctrl.reg_we && !rst && widx != '0;

  assign pc_plus4 = pc_q + 32'd4;
  assign br_tgt   = pc_plus4 + {sext[XLEN-3:0], 2'b00};
  assign j_tgt    = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign take_br  = ctrl.is_beq && (rd1 == rd2);

  always_comb begin
    if (ctrl.is_jump)  pc_next = j_tgt;
    else if (take_br)  pc_next = br_tgt;
    else               pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (ld_we && !ld_dmem) imem[ld_idx[IAW-1:0]] <= ld_word;
  end

  always_ff @(posedge clk) begin
    if (ld_we && ld_dmem)            dmem[ld_idx[DAW-1:0]] <= ld_word;
    else if (ctrl.mem_we && !rst)    dmem[alu_y[DAW+1:2]]  <= rd2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= '0;
      wb_we_o   <= 1'b0;
      wb_idx_o  <= '0;
      wb_data_o <= '0;
      st_we_o   <= 1'b0;
      st_addr_o <= '0;
      st_data_o <= '0;
    end else begin
      pc_q      <= pc_next;
      wb_we_o   <= rf_we;
      wb_idx_o  <= widx;
      wb_data_o <= wdata;
      st_we_o   <= ctrl.mem_we;
      st_addr_o <= alu_y;
      st_data_o <= rd2;
    end
  end

  assign pc_o = pc_q;
  assign unused_bits = ^{instr[10:6], pc_q[1:0], ld_idx, alu_y};

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (pc_q == '0 && !wb_we_o && !st_we_o)); // R1
  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst) pc_q[1:0] == 2'b00); // R2
  AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.is_beq && !ctrl.is_jump) |=> pc_q == $past(pc_q) + 32'd4); // R2
  AST_NO_R0_WRITE: assert property (@(posedge clk) disable iff (rst) wb_we_o |-> wb_idx_o != '0); // R5
  AST_STORE_REPORT: assert property (@(posedge clk) disable iff (rst)
    ctrl.mem_we |=> (st_we_o && st_data_o == $past(rd2))); // R7
  AST_BEQ_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
    (ctrl.is_beq && rd1 != rd2) |=> pc_q == $past(pc_q) + 32'd4); // R8
endmodule

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;
  localparam time CLKP = 20ns;
  logic clk = 1'b0, rst = 1'b1, ld_we = 1'b0, ld_dmem = 1'b0;
  logic [7:0] ld_idx = '0;
  logic [31:0] ld_word = '0;
  logic [31:0] pc_o, wb_data_o, st_addr_o, st_data_o;
  logic wb_we_o, st_we_o;
  logic [4:0] wb_idx_o;

  int errors = 0, checks = 0;
  logic [31:0] mregs [32];
  logic [31:0] mimem [64];
  logic [31:0] mdmem [64];
  logic [31:0] mpc;

  always #(CLKP/2) clk = ~clk;

  sc_core uut (.clk(clk), .rst(rst), .ld_we(ld_we), .ld_dmem(ld_dmem), .ld_idx(ld_idx),
    .ld_word(ld_word), .pc_o(pc_o), .wb_we_o(wb_we_o), .wb_idx_o(wb_idx_o),
    .wb_data_o(wb_data_o), .st_we_o(st_we_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rty(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'h00, fn};
  endfunction
  function automatic logic [31:0] ity(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  task automatic load(input bit dsel, input int idx, input logic [31:0] w);
    @(negedge clk);
    ld_we = 1'b1; ld_dmem = dsel; ld_idx = idx[7:0]; ld_word = w;
    @(negedge clk);
    ld_we = 1'b0;
    if (dsel) mdmem[idx] = w; else mimem[idx] = w;
  endtask

  // one retirement of the model, then compare ports after the matching edge
  task automatic step_and_check();
    logic [31:0] ins, a, b, sx, res, addr, npc;
    logic [5:0] op;
    logic ewb, est;
    logic [4:0] eidx;
    string tag;
    ins = mimem[mpc[7:2]];
    op = ins[31:26];
    a = mregs[ins[25:21]]; b = mregs[ins[20:16]];
    sx = {{16{ins[15]}}, ins[15:0]};
    npc = mpc + 4; ewb = 0; est = 0; eidx = 0; res = 0; addr = 0; tag = "R2";
    case (op)
      6'h00: begin
        ewb = 1; eidx = ins[15:11]; tag = "R3";
        case (ins[5:0])
          6'h20: res = a + b;
          6'h22: res = a - b;
          6'h24: res = a & b;
          6'h25: res = a | b;
          6'h2A: begin res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R4"; end
          default: begin ewb = 0; tag = "R2"; end
        endcase
        if (ewb && eidx == 0) begin ewb = 0; tag = "R5"; end
      end
      6'h23: begin addr = a + sx; res = mdmem[addr[7:2]]; eidx = ins[20:16]; ewb = (eidx != 0); tag = "R6"; end
      6'h2B: begin addr = a + sx; est = 1; mdmem[addr[7:2]] = b; tag = "R7"; end
      6'h04: begin if (a == b) npc = mpc + 4 + {sx[29:0], 2'b00}; tag = "R8"; end
      6'h02: begin npc = {npc[31:28], ins[25:0], 2'b00}; tag = "R9"; end
      default: ;
    endcase
    if (ewb) mregs[eidx] = res;
    mpc = npc;
    @(posedge clk); @(negedge clk);
    chk(pc_o === mpc, tag, "pc", pc_o, mpc);
    chk(wb_we_o === ewb, tag, "wb_we", {31'b0, wb_we_o}, {31'b0, ewb});
    if (ewb) begin
      chk(wb_idx_o === eidx, tag, "wb_idx", {27'b0, wb_idx_o}, {27'b0, eidx});
      chk(wb_data_o === res, tag, "wb_data", wb_data_o, res);
    end
    chk(st_we_o === est, tag, "st_we", {31'b0, st_we_o}, {31'b0, est});
    if (est) begin
      chk(st_addr_o === addr, tag, "st_addr", st_addr_o, addr);
      chk(st_data_o === b, tag, "st_data", st_data_o, b);
    end
  endtask

  initial begin
    #(CLKP * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] prog [25];
    for (int i = 0; i < 32; i++) mregs[i] = '0;
    prog[0]  = ity(6'h23, 0, 1, 16'd0);
    prog[1]  = ity(6'h23, 0, 2, 16'd4);
    prog[2]  = ity(6'h23, 0, 3, 16'd8);
    prog[3]  = rty(1, 3, 4, 6'h20);
    prog[4]  = rty(3, 1, 5, 6'h22);
    prog[5]  = rty(1, 2, 6, 6'h24);
    prog[6]  = rty(1, 2, 7, 6'h25);
    prog[7]  = rty(2, 3, 8, 6'h2A);
    prog[8]  = rty(3, 2, 9, 6'h2A);
    prog[9]  = rty(1, 1, 0, 6'h20);
    prog[10] = rty(0, 3, 10, 6'h20);
    prog[11] = ity(6'h2B, 0, 4, 16'd12);
    prog[12] = ity(6'h23, 0, 12, 16'd12);
    prog[13] = ity(6'h23, 2, 13, 16'd24);
    prog[14] = 32'hFC00_0000;
    prog[15] = ity(6'h04, 3, 10, 16'd2);
    prog[16] = rty(1, 1, 14, 6'h20);
    prog[17] = rty(1, 1, 14, 6'h20);
    prog[18] = ity(6'h04, 1, 2, 16'd5);
    prog[19] = {6'h02, 26'd24};
    for (int i = 20; i < 24; i++) prog[i] = rty(1, 1, 15, 6'h20);
    prog[24] = ity(6'h04, 0, 0, 16'hFFFF);
    // R10: fill both memories through the load port
    for (int i = 0; i < 64; i++) load(1'b0, i, (i < 25) ? prog[i] : 32'h0);
    for (int i = 0; i < 64; i++) load(1'b1, i, 32'h0);
    load(1'b1, 0, 32'h1111_1111);
    load(1'b1, 1, 32'hFFFF_FFF0);
    load(1'b1, 2, 32'd5);
    // R1: reset state
    @(negedge clk);
    chk(pc_o === 32'h0, "R1", "pc in reset", pc_o, 32'h0);
    chk(wb_we_o === 1'b0, "R1", "wb_we in reset", {31'b0, wb_we_o}, 32'h0);
    chk(st_we_o === 1'b0, "R1", "st_we in reset", {31'b0, st_we_o}, 32'h0);
    mpc = 0;
    rst = 1'b0;
    for (int c = 0; c < 34; c++) step_and_check();
    chk(pc_o === 32'd96, "R8", "self branch holds pc", pc_o, 32'd96);
    // R1: reset mid-run, registers and data memory keep their contents
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(pc_o === 32'h0, "R1", "pc after re-reset", pc_o, 32'h0);
    chk(wb_we_o === 1'b0, "R1", "wb_we after re-reset", {31'b0, wb_we_o}, 32'h0);
    rst = 1'b0; mpc = 0;
    for (int c = 0; c < 30; c++) step_and_check();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule